// File: doc/BRIEF.md
# Lock-Aware PLL Bypass Clock Selector

This block sits right after a PLL and chooses the clock that goes downstream. The choice is the PLL reference clock, the PLL output clock, or no clock at all. It decides from a 2-bit mode code, a PLL enable bit and the PLL lock indicator, which arrives asynchronously. The choice is made separately in each clock domain.

Switching between the two sources never produces a runt pulse. Each source owns a select flop that changes only while its own clock is low. A source is connected only after the other source is seen, through a synchronizer, to be disconnected.

The block also drives the enable for the analog PLL circuit. When enable is removed, the output is first moved off the PLL clock. Only then is the PLL circuit enable withdrawn.

The mode, enable and lock inputs are expected to hold steady for at least one handover window between changes. The mode code is treated as automatic (code 0) while system reset holds it there.

Top module: `pll_clk_sel`

## Requirements
- R1: Mode code 0 (automatic), with enable high: the output carries the reference clock while lock is low and the PLL clock while lock is high.
- R2: Mode code 1 (locked or nothing), with enable high: the output carries the PLL clock while lock is high and no clock while lock is low.
- R3: Mode code 2 (forced reference): the output carries the reference clock whatever the state of lock and enable.
- R4: Mode code 3 (forced PLL), with enable high: the output carries the PLL clock whatever the state of lock.
- R5: With enable low, mode code 0 carries the reference clock, and mode codes 1 and 3 carry no clock.
- R6: The two sources are never connected at the same time. No high or low phase of `clk_o` is shorter than half a period of the faster source, including across mode changes made while the PLL runs.
- R7: After lock falls in mode 0 with the PLL output selected, the reference clock drives `clk_o` within seven cycles of the slower source clock.
- R8: `pll_en_o` follows enable high. When enable falls, `pll_en_o` stays high until the PLL source is disconnected, so no PLL-clock pulse reaches `clk_o` after `pll_en_o` falls.
- R9: `active_o` is high exactly when some source is connected to `clk_o`.
- R10: While `rst_ni` is low, `clk_o`, `active_o` and `pll_en_o` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk_i | input | 1 | PLL reference clock; also clocks the enable sequencer |
| pll_clk_i | input | 1 | PLL output clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | PLL lock indicator, asynchronous |
| enable_i | input | 1 | PLL enable request |
| mode_i | input | 2 | Selection mode code: 0 automatic, 1 locked-or-nothing, 2 forced reference, 3 forced PLL |
| clk_o | output | 1 | Selected downstream clock |
| active_o | output | 1 | High while a source is connected to `clk_o` |
| pll_en_o | output | 1 | Enable for the analog PLL circuit |

## Verification
Two functions can act in the same cycle: the lock-driven handover and the disable sequence. Both are provoked by dropping enable and lock together while the PLL clock is selected in automatic mode. The bench records the time of the last output pulse that has the PLL's width and the time at which `pll_en_o` falls. It passes the case only if the PLL pulse ends before the enable falls and the output then settles on the reference clock. A pulse-width monitor runs for the whole bench and catches any runt phase produced across these transitions.

// File: rtl/pcs_pkg.sv
`timescale 1ns/1ps
package pcs_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_REF  = 2'd1,
    SRC_PLL  = 2'd2
  } src_e;

  typedef enum logic [1:0] {
    MODE_AUTO      = 2'd0,
    MODE_LOCK_GATE = 2'd1,
    MODE_FORCE_REF = 2'd2,
    MODE_FORCE_PLL = 2'd3
  } mode_e;

  function automatic src_e pick_src(logic [1:0] mode, logic en, logic lock);
    src_e s;
    case (mode_e'(mode))
      MODE_AUTO:      s = (en && lock) ? SRC_PLL : SRC_REF;
      MODE_LOCK_GATE: s = (en && lock) ? SRC_PLL : SRC_NONE;
      MODE_FORCE_REF: s = SRC_REF;
      default:        s = en ? SRC_PLL : SRC_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/pcs_sync.sv
`timescale 1ns/1ps
module pcs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pcs_branch.sv
`timescale 1ns/1ps
module pcs_branch import pcs_pkg::*; #(
  parameter src_e MY_SRC = SRC_REF,
  parameter int   STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       en_i,
  input  logic       lock_i,
  input  logic       peer_on_i,
  output logic       sel_o
);
  localparam int CW = 5;

  logic [CW-1:0] ctl_s;
  logic [1:0]    mode_s;
  logic          en_s, lock_s, peer_s, want, sel_q;

  pcs_sync #(.W(CW), .STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({mode_i, en_i, lock_i, peer_on_i}),
    .q_o    (ctl_s)
  );

  assign {mode_s, en_s, lock_s, peer_s} = ctl_s;
  assign want = (pick_src(mode_s, en_s, lock_s) == MY_SRC);

  // select changes only while own clock is low; waits for peer to detach
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= want & ~peer_s;
  end

  assign sel_o = sel_q;

  // R1..R5: a source is never connected without the decoded mode asking for it
  assert_grant_needs_want_R1: assert property (
    @(posedge clk_i) disable iff (!rst_ni) !want |-> !sel_q
  ) else $error("source connected without request");
endmodule

// File: rtl/pcs_en_seq.sv
`timescale 1ns/1ps
module pcs_en_seq #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pll_on_i,
  output logic pll_en_o
);
  logic [1:0] s;
  logic       en_s, pll_on_s, pll_en_q;

  pcs_sync #(.W(2), .STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({en_i, pll_on_i}),
    .q_o    (s)
  );
  assign {en_s, pll_on_s} = s;

  // power up at once; power down only once the PLL source is seen detached
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pll_en_q <= 1'b0;
    else if (en_s)      pll_en_q <= 1'b1;
    else if (!pll_on_s) pll_en_q <= 1'b0;
  end

  assign pll_en_o = pll_en_q;

  assert_en_follow_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni) en_s |=> pll_en_q
  ) else $error("PLL enable did not follow request");

  assert_hold_until_detach_R8: assert property (
    @(posedge clk_i) disable iff (!rst_ni) (pll_en_q && pll_on_s) |=> pll_en_q
  ) else $error("PLL enable dropped while PLL source attached");
endmodule

// File: rtl/pll_clk_sel.sv
`timescale 1ns/1ps
module pll_clk_sel import pcs_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       ref_clk_i,
  input  logic       pll_clk_i,
  input  logic       rst_ni,
  input  logic       lock_i,
  input  logic       enable_i,
  input  logic [1:0] mode_i,
  output logic       clk_o,
  output logic       active_o,
  output logic       pll_en_o
);
  logic ref_on, pll_on;

  pcs_branch #(.MY_SRC(SRC_REF), .STAGES(SYNC_STAGES)) u_ref_br (
    .clk_i     (ref_clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .en_i      (enable_i),
    .lock_i    (lock_i),
    .peer_on_i (pll_on),
    .sel_o     (ref_on)
  );

  pcs_branch #(.MY_SRC(SRC_PLL), .STAGES(SYNC_STAGES)) u_pll_br (
    .clk_i     (pll_clk_i),
    .rst_ni    (rst_ni),
    .mode_i    (mode_i),
    .en_i      (enable_i),
    .lock_i    (lock_i),
    .peer_on_i (ref_on),
    .sel_o     (pll_on)
  );

  pcs_en_seq #(.STAGES(SYNC_STAGES)) u_en_seq (
    .clk_i    (ref_clk_i),
    .rst_ni   (rst_ni),
    .en_i     (enable_i),
    .pll_on_i (pll_on),
    .pll_en_o (pll_en_o)
  );

  assign clk_o    = (ref_clk_i & ref_on) | (pll_clk_i & pll_on);
  assign active_o = ref_on | pll_on;

  always_comb begin
    if (rst_ni) begin
      assert_one_src_R6: assert (!(ref_on && pll_on))
        else $error("both sources connected");
    end
  end

  assert_pll_off_detached_R8: assert property (
    @(posedge ref_clk_i) disable iff (!rst_ni) !pll_en_o |-> !pll_on
  ) else $error("PLL source attached while PLL disabled");
endmodule

// File: tb/pll_clk_sel_bench.sv
`timescale 1ns/1ps
module pll_clk_sel_bench;
  logic       ref_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b1;
  logic       lock = 1'b0, en = 1'b0;
  logic [1:0] mode = 2'd0;
  logic       clk_o, active, pll_en;

  int n_run = 0, n_fail = 0, edges = 0, glitches = 0;
  realtime t_rise = 0.0, t_fall = 0.0, t_last_pll = 0.0, t_en_fall = 0.0;

  pll_clk_sel u_pll_clk_sel (
    .ref_clk_i (ref_clk),
    .pll_clk_i (pll_clk),
    .rst_ni    (rst_n),
    .lock_i    (lock),
    .enable_i  (en),
    .mode_i    (mode),
    .clk_o     (clk_o),
    .active_o  (active),
    .pll_en_o  (pll_en)
  );

  always #2.5 ref_clk = ~ref_clk;                       // 200 MHz
  initial forever #1.5 pll_clk = pll_en ? ~pll_clk : 1'b0; // PLL runs only while enabled

  always @(posedge clk_o) begin
    edges++;
    if (t_fall > 0.0 && ($realtime - t_fall) < 1.0) glitches++;
    t_rise = $realtime;
  end
  always @(negedge clk_o) begin
    if (($realtime - t_rise) < 1.0) glitches++;
    if (($realtime - t_rise) < 2.0) t_last_pll = $realtime;
    t_fall = $realtime;
  end
  always @(negedge pll_en) t_en_fall = $realtime;

  // {mode[5:4], enable[3], lock[2], expected source[1:0]}: 0 none, 1 ref, 2 pll
  localparam logic [5:0] VEC [13] = '{
    6'b00_0_0_01, 6'b00_1_0_01, 6'b00_1_1_10, 6'b01_1_1_10,
    6'b01_1_0_00, 6'b01_0_0_00, 6'b10_1_1_01, 6'b10_1_0_01,
    6'b11_1_0_10, 6'b11_0_0_00, 6'b11_1_1_10, 6'b00_1_1_10,
    6'b10_0_0_01
  };

  task automatic check(string tag, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic measure(output int src);
    int c0, n;
    c0 = edges;
    #200;
    n = edges - c0;
    if (n == 0)                 src = 0;
    else if (n >= 35 && n <= 45) src = 1;
    else if (n >= 60 && n <= 72) src = 2;
    else                         src = 3;
  endtask

  function automatic string vec_tag(logic [1:0] m, logic e);
    if (m == 2'd2) return "R3 forced ref";
    if (!e)        return "R5 disabled";
    case (m)
      2'd0:    return "R1 auto";
      2'd1:    return "R2 locked-or-nothing";
      default: return "R4 forced pll";
    endcase
  endfunction

  initial begin
    #50000;
    n_fail++;
    $display("FAIL R10 watchdog expired actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int src;
    realtime t_cmd, tr, w;
    #1   rst_n = 1'b0;
    #11.3;
    check("R10 reset clk_o", int'(clk_o), 0);
    check("R10 reset active_o", int'(active), 0);
    check("R10 reset pll_en_o", int'(pll_en), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 13; i++) begin
      {mode, en, lock} = VEC[i][5:2];
      #80;
      measure(src);
      check($sformatf("%s vec%0d source", vec_tag(mode, en), i), src, int'(VEC[i][1:0]));
      check($sformatf("R9 vec%0d active_o", i), int'(active), int'(VEC[i][1:0] != 2'd0));
      check($sformatf("R8 vec%0d pll_en_o", i), int'(pll_en), int'(en));
    end

    // R7: lock falls with PLL selected; reference must drive within 7 ref cycles
    mode = 2'd0; en = 1'b1; lock = 1'b1;
    #100;
    lock = 1'b0;
    #35;
    @(posedge clk_o); tr = $realtime;
    @(negedge clk_o); w = $realtime - tr;
    check("R7 handover pulse is reference width", int'(w > 2.0), 1);

    // R8: enable and lock drop together from a locked PLL selection
    lock = 1'b1;
    #100;
    t_cmd = $realtime;
    en = 1'b0; lock = 1'b0;
    #100;
    check("R8 pll_en_o fell after disable", int'(t_en_fall > t_cmd), 1);
    check("R8 last PLL pulse before pll_en_o fall", int'(t_last_pll < t_en_fall), 1);
    measure(src);
    check("R5 disabled auto falls back to ref", src, 1);

    check("R6 no runt phases on clk_o", glitches, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule